// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block interprets the bus writes that reach a parallel NOR flash using the JEDEC-style unlock protocol. Every write is taken as a command cycle. The block counts the cycles of the two-write unlock preamble and dispatches the commands that follow it: word program, sector erase, chip erase, autoselect (ID), CFI query and unlock bypass. Any write it does not expect sends it back to read mode.

The block holds a small byte array. A program cycle ANDs the written bytes into the array. An erase walks a word counter through the target range and writes 0xFF, one 32-bit word per clock, with `busy_o` high for the whole walk. The current command mode, the bypass flag and a one-cycle program or erase strobe with its address are brought out for the status and read-path logic. A byte read port exposes the array contents.

The command word offset is the byte address masked to the sector size and then scaled down by the access width. A read-only build runs the same command sequences but leaves the array untouched.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset the mode is read (code 0), bypass is 0, busy is 0, both strobes are 0 and every array byte reads 0xFF.
- R2: In read mode, 0xAA at unlock offset 0 (0x55) moves to mode 1. In mode 1, 0x55 at unlock offset 1 (0x2A) moves to command mode 2. A wrong value or a wrong offset in either cycle returns to mode 0.
- R3: In command mode, the data selects the next mode: 0xA0 goes to program (3), 0x90 to autoselect (4), 0x80 to erase setup (5), and 0x20 sets bypass and stays in mode 2. Any other value returns to mode 0. Without bypass, the command write must be at unlock offset 0, otherwise the block returns to mode 0.
- R4: Data 0xF0 returns to mode 0 and clears bypass from every mode except program (3) and erasing (8). In program mode, 0xF0 is taken as program data.
- R5: Data 0x98 at word offset 0x55 enters CFI mode (9) from mode 0 or mode 4. Any write in mode 9 returns to mode 0.
- R6: A write in program mode ANDs data byte i into array byte addr+i, for 1, 2 or 4 bytes (width code 0, 1, 2). The bytes are little-endian and the address wraps at the end of the array. One cycle after the write, `prog_o` pulses for one cycle with `op_addr_o` equal to the write address.
- R7: With bypass set, the command cycle ignores the address. A completed program returns to mode 2 with bypass still set. In autoselect, 0x00 returns to mode 0 with bypass cleared.
- R8: From erase setup, 0xAA at offset 0x55 goes to mode 6 and 0x55 at offset 0x2A goes to mode 7. In mode 7, 0x10 at offset 0x55 starts a chip erase, 0x30 at any address starts an erase of that address's sector, and any other write returns to mode 0. An erase enters mode 8 and pulses `erase_o` with `op_addr_o` equal to the base of the erased range. It holds `busy_o` for exactly one cycle per 32-bit word of the range (256 for the chip, 128 for a sector) and fills the range with 0xFF. At the end it returns to mode 0, or to mode 2 if bypass is set.
- R9: Writes during an erase, 0xF0 included, do not change the mode or the array.
- R10: The word offset is `addr[8:0]` shifted right by 0, 1 or 2 for width codes 0, 1 and 2 (code 3 counts as 2). Bits of the address above the sector are ignored.
- R11: A read-only build follows the same mode sequence and the same busy timing, but its array stays all 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe, one cycle per bus write |
| addr_i | input | 10 | Byte address |
| wdata_i | input | 32 | Write data; the low byte is the command |
| width_i | input | 2 | Access width: 0 byte, 1 half-word, 2 word |
| rd_addr_i | input | 10 | Array read address |
| mode_o | output | 4 | Current command mode code |
| bypass_o | output | 1 | Unlock bypass active |
| busy_o | output | 1 | Erase fill in progress |
| prog_o | output | 1 | Program strobe |
| erase_o | output | 1 | Erase start strobe |
| op_addr_o | output | 10 | Address of the last program or erase |
| rd_data_o | output | 8 | Array byte at `rd_addr_i` |

## Verification
Mode, bypass, the strobes, `op_addr_o` and the array contents all change on the clock edge that samples a write. The bench therefore drives each write on a falling edge and checks its results on the next falling edge, which comes after exactly one rising edge. The array read port is combinational and is swept while the block is idle. The erase duration is measured by counting the falling edges at which `busy_o` is high, so writes placed inside the erase do not disturb the count. The strobes are checked again one cycle later to confirm they have dropped.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

  typedef enum logic [3:0] {
    MD_READ  = 4'd0,
    MD_UNLK  = 4'd1,
    MD_CMD   = 4'd2,
    MD_PROG  = 4'd3,
    MD_ID    = 4'd4,
    MD_ESET  = 4'd5,
    MD_EUNLK = 4'd6,
    MD_ECMD  = 4'd7,
    MD_ERASE = 4'd8,
    MD_CFI   = 4'd9
  } mode_e;

  localparam logic [7:0] C_KEY_A   = 8'hAA;
  localparam logic [7:0] C_KEY_B   = 8'h55;
  localparam logic [7:0] C_PROG    = 8'hA0;
  localparam logic [7:0] C_ID      = 8'h90;
  localparam logic [7:0] C_ESET    = 8'h80;
  localparam logic [7:0] C_BYPASS  = 8'h20;
  localparam logic [7:0] C_RESET   = 8'hF0;
  localparam logic [7:0] C_QUERY   = 8'h98;
  localparam logic [7:0] C_CHIP    = 8'h10;
  localparam logic [7:0] C_SECTOR  = 8'h30;

  function automatic logic [1:0] width_shift(input logic [1:0] w);
    return (w == 2'd3) ? 2'd2 : w;
  endfunction

  function automatic logic [2:0] width_bytes(input logic [1:0] w);
    case (w)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm
  import nor_seq_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int SECT_W  = 9,
  parameter int UNLOCK0 = 'h55,
  parameter int UNLOCK1 = 'h2A,
  parameter int CFI_OFS = 'h55
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        cmd_i,
  input  logic [1:0]        width_i,
  input  logic              erase_done_i,
  output mode_e             mode_o,
  output logic              bypass_o,
  output logic              pgm_fire_o,
  output logic              er_start_o,
  output logic              er_chip_o,
  output logic              prog_o,
  output logic              erase_o,
  output logic [ADDR_W-1:0] op_addr_o
);

  localparam logic [SECT_W-1:0] U0_OFS = SECT_W'(UNLOCK0);
  localparam logic [SECT_W-1:0] U1_OFS = SECT_W'(UNLOCK1);
  localparam logic [SECT_W-1:0] Q_OFS  = SECT_W'(CFI_OFS);

  mode_e st_q, st_d;
  logic  bp_q, bp_d, go_rd;
  logic  prog_q, erase_q;
  logic [ADDR_W-1:0] op_q;
  logic [SECT_W-1:0] boff;
  logic  hit_u0, hit_u1, hit_q;

  assign boff   = addr_i[SECT_W-1:0] >> width_shift(width_i);
  assign hit_u0 = (boff == U0_OFS);
  assign hit_u1 = (boff == U1_OFS);
  assign hit_q  = (boff == Q_OFS);

  always_comb begin
    st_d       = st_q;
    bp_d       = bp_q;
    go_rd      = 1'b0;
    pgm_fire_o = 1'b0;
    er_start_o = 1'b0;
    er_chip_o  = 1'b0;
    if (st_q == MD_ERASE) begin
      if (erase_done_i) st_d = bp_q ? MD_CMD : MD_READ;
    end else if (wr_i) begin
      if (cmd_i == C_RESET && st_q != MD_PROG) begin
        go_rd = 1'b1;
      end else begin
        unique case (st_q)
          MD_READ: begin
            if (hit_q && cmd_i == C_QUERY)       st_d = MD_CFI;
            else if (hit_u0 && cmd_i == C_KEY_A) st_d = MD_UNLK;
            else                                 go_rd = 1'b1;
          end
          MD_UNLK:  if (hit_u1 && cmd_i == C_KEY_B) st_d = MD_CMD;  else go_rd = 1'b1;
          MD_CMD: begin
            if (!bp_q && !hit_u0) go_rd = 1'b1;
            else begin
              case (cmd_i)
                C_BYPASS: bp_d = 1'b1;
                C_PROG:   st_d = MD_PROG;
                C_ID:     st_d = MD_ID;
                C_ESET:   st_d = MD_ESET;
                default:  go_rd = 1'b1;
              endcase
            end
          end
          MD_PROG: begin
            pgm_fire_o = 1'b1;
            st_d       = bp_q ? MD_CMD : MD_READ;
          end
          // 0x00 with bypass and every other non-query write both exit here
          MD_ID:    if (hit_q && cmd_i == C_QUERY)  st_d = MD_CFI;  else go_rd = 1'b1;
          MD_ESET:  if (hit_u0 && cmd_i == C_KEY_A) st_d = MD_EUNLK; else go_rd = 1'b1;
          MD_EUNLK: if (hit_u1 && cmd_i == C_KEY_B) st_d = MD_ECMD;  else go_rd = 1'b1;
          MD_ECMD: begin
            if (cmd_i == C_CHIP && hit_u0) begin
              st_d = MD_ERASE; er_start_o = 1'b1; er_chip_o = 1'b1;
            end else if (cmd_i == C_SECTOR) begin
              st_d = MD_ERASE; er_start_o = 1'b1;
            end else go_rd = 1'b1;
          end
          default: go_rd = 1'b1;
        endcase
      end
    end
    if (go_rd) begin
      st_d = MD_READ;
      bp_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= MD_READ;
      bp_q    <= 1'b0;
      prog_q  <= 1'b0;
      erase_q <= 1'b0;
      op_q    <= '0;
    end else begin
      st_q    <= st_d;
      bp_q    <= bp_d;
      prog_q  <= pgm_fire_o;
      erase_q <= er_start_o;
      if (pgm_fire_o)      op_q <= addr_i;
      else if (er_start_o) op_q <= er_chip_o ? '0 : {addr_i[ADDR_W-1:SECT_W], {SECT_W{1'b0}}};
    end
  end

  assign mode_o    = st_q;
  assign bypass_o  = bp_q;
  assign prog_o    = prog_q;
  assign erase_o   = erase_q;
  assign op_addr_o = op_q;

  a_r1_read_no_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == MD_READ) |-> !bp_q);
  a_r9_erase_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == MD_ERASE && !erase_done_i) |=> (st_q == MD_ERASE));
  a_r6_prog_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && st_q == MD_PROG) |=> (prog_q && (st_q == MD_READ || st_q == MD_CMD)));
  a_r7_bypass_returns: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && st_q == MD_PROG && bp_q) |=> (st_q == MD_CMD && bp_q));

endmodule

// File: rtl/nor_erase_ctr.sv
module nor_erase_ctr #(
  parameter int ADDR_W = 10,
  parameter int SECT_W = 9
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic                     chip_i,
  input  logic [ADDR_W-SECT_W-1:0] sect_i,
  output logic                     active_o,
  output logic                     done_o,
  output logic [ADDR_W-3:0]        word_o
);

  localparam int WORD_W = ADDR_W - 2;
  localparam int SWORD_W = SECT_W - 2;

  logic              act_q;
  logic [WORD_W-1:0] word_q, last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      word_q <= '0;
      last_q <= '0;
    end else if (start_i) begin
      act_q  <= 1'b1;
      word_q <= chip_i ? '0 : {sect_i, {SWORD_W{1'b0}}};
      last_q <= chip_i ? '1 : {sect_i, {SWORD_W{1'b1}}};
    end else if (act_q) begin
      if (word_q == last_q) act_q <= 1'b0;
      else                  word_q <= word_q + 1'b1;
    end
  end

  assign active_o = act_q;
  assign done_o   = act_q && (word_q == last_q);
  assign word_o   = word_q;

  a_r8_word_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q |-> (word_q <= last_q));
  a_r9_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !act_q);

endmodule

// File: rtl/nor_byte_array.sv
module nor_byte_array #(
  parameter int ADDR_W    = 10,
  parameter bit READ_ONLY = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pgm_en_i,
  input  logic [ADDR_W-1:0] pgm_addr_i,
  input  logic [31:0]       pgm_data_i,
  input  logic [1:0]        pgm_width_i,
  input  logic              fill_en_i,
  input  logic [ADDR_W-3:0] fill_word_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o
);

  import nor_seq_pkg::*;

  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];
  logic       pgm_ok, fill_ok;
  logic [2:0] nbytes;

  generate
    if (READ_ONLY) begin : g_ro
      assign pgm_ok  = 1'b0;
      assign fill_ok = 1'b0;
    end else begin : g_rw
      assign pgm_ok  = pgm_en_i;
      assign fill_ok = fill_en_i;
    end
  endgenerate

  assign nbytes = width_bytes(pgm_width_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else begin
      if (pgm_ok) begin
        for (int b = 0; b < 4; b++) begin
          if (b < int'(nbytes))
            mem[pgm_addr_i + ADDR_W'(b)] <= mem[pgm_addr_i + ADDR_W'(b)] & pgm_data_i[8*b +: 8];
        end
      end
      if (fill_ok) begin
        for (int b = 0; b < 4; b++) mem[{fill_word_i, 2'(b)}] <= 8'hFF;
      end
    end
  end

  assign rd_data_o = mem[rd_addr_i];

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_seq_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int SECT_W    = 9,
  parameter int UNLOCK0   = 'h55,
  parameter int UNLOCK1   = 'h2A,
  parameter int CFI_OFS   = 'h55,
  parameter bit READ_ONLY = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic [1:0]        width_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [3:0]        mode_o,
  output logic              bypass_o,
  output logic              busy_o,
  output logic              prog_o,
  output logic              erase_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic [7:0]        rd_data_o
);

  mode_e             mode;
  logic              pgm_fire, er_start, er_chip, er_done, er_act;
  logic [ADDR_W-3:0] fill_word;

  nor_cmd_fsm #(
    .ADDR_W(ADDR_W), .SECT_W(SECT_W),
    .UNLOCK0(UNLOCK0), .UNLOCK1(UNLOCK1), .CFI_OFS(CFI_OFS)
  ) u_fsm (
    .clk_i, .rst_ni, .wr_i, .addr_i,
    .cmd_i        (wdata_i[7:0]),
    .width_i,
    .erase_done_i (er_done),
    .mode_o       (mode),
    .bypass_o,
    .pgm_fire_o   (pgm_fire),
    .er_start_o   (er_start),
    .er_chip_o    (er_chip),
    .prog_o, .erase_o, .op_addr_o
  );

  nor_erase_ctr #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_ctr (
    .clk_i, .rst_ni,
    .start_i  (er_start),
    .chip_i   (er_chip),
    .sect_i   (addr_i[ADDR_W-1:SECT_W]),
    .active_o (er_act),
    .done_o   (er_done),
    .word_o   (fill_word)
  );

  nor_byte_array #(.ADDR_W(ADDR_W), .READ_ONLY(READ_ONLY)) u_mem (
    .clk_i, .rst_ni,
    .pgm_en_i    (pgm_fire),
    .pgm_addr_i  (addr_i),
    .pgm_data_i  (wdata_i),
    .pgm_width_i (width_i),
    .fill_en_i   (er_act),
    .fill_word_i (fill_word),
    .rd_addr_i,
    .rd_data_o
  );

  assign mode_o = mode;
  assign busy_o = er_act;

  a_r8_busy_in_erase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (mode == MD_ERASE));

endmodule

// File: tb/nor_cmd_seq_tb.sv
`timescale 1ns/1ps
module nor_cmd_seq_tb_top;

  localparam int AW = 10;
  localparam int DEPTH = 1 << AW;
  localparam int U0 = 'h55;
  localparam int U1 = 'h2A;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [1:0]    width = '0;
  logic [AW-1:0] rd_addr = '0;

  logic [3:0]    mode, ro_mode;
  logic          bypass, busy, prog, erase, ro_bypass, ro_busy, ro_prog, ro_erase;
  logic [AW-1:0] op_addr, ro_op_addr;
  logic [7:0]    rd_data, ro_rd_data;

  int n_chk = 0;
  int n_bad = 0;
  int busy_cnt = 0;
  logic [7:0] ref_mem [DEPTH];

  always #2.5 clk = ~clk;

  nor_cmd_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .width_i(width), .rd_addr_i(rd_addr), .mode_o(mode), .bypass_o(bypass),
    .busy_o(busy), .prog_o(prog), .erase_o(erase), .op_addr_o(op_addr),
    .rd_data_o(rd_data)
  );

  nor_cmd_seq #(.READ_ONLY(1'b1)) dut_ro_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .width_i(width), .rd_addr_i(rd_addr), .mode_o(ro_mode), .bypass_o(ro_bypass),
    .busy_o(ro_busy), .prog_o(ro_prog), .erase_o(ro_erase), .op_addr_o(ro_op_addr),
    .rd_data_o(ro_rd_data)
  );

  always @(negedge clk) if (busy) busy_cnt++;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_mode(input string req, input int exp);
    chk(req, int'(mode), exp);
    chk({req, " R11 ro"}, int'(ro_mode), exp);
  endtask

  task automatic wr_cyc(input int a, input int d, input int w);
    @(negedge clk);
    wr = 1'b1; addr = AW'(a); wdata = 32'(d); width = 2'(w);
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic unlock(input int w);
    wr_cyc(U0 << w, 'hAA, w);
    wr_cyc(U1 << w, 'h55, w);
  endtask

  task automatic model_prog(input int a, input logic [31:0] d, input int w);
    int n;
    n = (w == 0) ? 1 : (w == 1) ? 2 : 4;
    for (int b = 0; b < n; b++) ref_mem[(a + b) % DEPTH] &= d[8*b +: 8];
  endtask

  task automatic chk_array(input string req);
    int bad, first_a, act, exp;
    bad = 0; first_a = -1; act = 0; exp = 0;
    for (int a = 0; a < DEPTH; a++) begin
      rd_addr = AW'(a);
      #0.1;
      if (rd_data !== ref_mem[a] || ro_rd_data !== 8'hFF) begin
        if (first_a < 0) begin
          first_a = a;
          act = (rd_data !== ref_mem[a]) ? int'(rd_data) : int'(ro_rd_data);
          exp = (rd_data !== ref_mem[a]) ? int'(ref_mem[a]) : 'hFF;
        end
        bad++;
      end
    end
    n_chk++;
    if (bad != 0) begin
      n_bad++;
      $display("FAIL %s array byte %0h actual=%0h expected=%0h (%0d bad)", req, first_a, act, exp, bad);
    end
  endtask

  task automatic wait_idle(input string req);
    int t;
    t = 0;
    while (busy && t < 4000) begin @(negedge clk); t++; end
    if (busy) chk({req, " busy timeout"}, 1, 0);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int a = 0; a < DEPTH; a++) ref_mem[a] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk_mode("R1 mode", 0);
    chk("R1 bypass", int'(bypass), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 strobes", int'({prog, erase}), 0);
    chk_array("R1");

    // R2 unlock pair and mismatches
    wr_cyc(U0, 'hAA, 0); chk_mode("R2 first key", 1);
    wr_cyc(U1, 'h55, 0); chk_mode("R2 second key", 2);
    wr_cyc(U0, 'hF0, 0); chk_mode("R4 reset from cmd", 0);
    wr_cyc(U0, 'hAA, 0); wr_cyc(U1, 'h56, 0); chk_mode("R2 bad data", 0);
    wr_cyc('h56, 'hAA, 0); chk_mode("R2 bad addr first", 0);
    wr_cyc(U0, 'hAA, 0); wr_cyc('h2B, 'h55, 0); chk_mode("R2 bad addr second", 0);

    // R3 command decode
    unlock(0); wr_cyc('h100, 'h90, 0); chk_mode("R3 cmd off unlock addr", 0);
    unlock(0); wr_cyc(U0, 'h90, 0); chk_mode("R3 autoselect", 4);
    wr_cyc(U0, 'hF0, 0); chk_mode("R4 reset from id", 0);
    unlock(0); wr_cyc(U0, 'h77, 0); chk_mode("R3 unknown cmd", 0);
    unlock(0); wr_cyc(U0, 'h80, 0); chk_mode("R3 erase setup", 5);
    wr_cyc(U0, 'h33, 0); chk_mode("R8 bad erase key", 0);

    // R5 CFI entry and exit
    wr_cyc('h55, 'h98, 0); chk_mode("R5 cfi from read", 9);
    wr_cyc('h3, 'h12, 0); chk_mode("R5 exit cfi", 0);
    unlock(0); wr_cyc(U0, 'h90, 0);
    wr_cyc('h55, 'h98, 0); chk_mode("R5 cfi from id", 9);
    wr_cyc('h0, 'hF0, 0); chk_mode("R5 exit cfi f0", 0);

    // R6 program sweep over widths, overlapping addresses
    for (int w = 0; w < 3; w++) begin
      for (int k = 0; k < 4; k++) begin
        int a;
        logic [31:0] d;
        a = 'h300 + k * 3 + w * 5;
        d = 32'h5AC3967E ^ (32'(k) * 32'h01234567) ^ (32'(w) << 12);
        unlock(0); wr_cyc(U0, 'hA0, 0); chk_mode("R3 program", 3);
        wr_cyc(a, int'(d), w);
        model_prog(a, d, w);
        chk_mode("R6 back to read", 0);
        chk("R6 prog strobe", int'(prog), 1);
        chk("R6 op addr", int'(op_addr), a);
      end
    end
    @(negedge clk); chk("R6 strobe one cycle", int'(prog), 0);
    unlock(0); wr_cyc(U0, 'hA0, 0);
    wr_cyc('h3FE, 'h1234A5F0, 2); model_prog('h3FE, 32'h1234A5F0, 2);
    chk("R6 wrap strobe", int'(prog), 1);
    unlock(0); wr_cyc(U0, 'hA0, 0);
    wr_cyc('h3F0, 'hF0, 0); model_prog('h3F0, 32'hF0, 0);
    chk_mode("R4 f0 as data", 0);
    chk_array("R6");

    // R10 word offset scaling
    unlock(1); chk_mode("R10 half unlock", 2);
    wr_cyc('hAA + 'h200, 'h90, 1); chk_mode("R10 upper bits ignored", 4);
    wr_cyc(0, 'hF0, 1);
    unlock(2); chk_mode("R10 word unlock", 2);
    wr_cyc(0, 'hF0, 2);
    wr_cyc('h55, 'hAA, 1); chk_mode("R10 byte addr at half width", 0);

    // R7 bypass
    unlock(0); wr_cyc(U0, 'h20, 0);
    chk_mode("R7 bypass cmd", 2); chk("R7 bypass set", int'(bypass), 1);
    wr_cyc('h123, 'hA0, 0); chk_mode("R7 addr ignored", 3);
    wr_cyc('h200, 'h5A, 0); model_prog('h200, 32'h5A, 0);
    chk_mode("R7 back to cmd", 2); chk("R7 bypass kept", int'(bypass), 1);
    wr_cyc('h201, 'hA0, 0); wr_cyc('h201, 'h3C3C, 1); model_prog('h201, 32'h3C3C, 1);
    chk_mode("R7 second program", 2);
    wr_cyc('h7, 'h90, 0); chk_mode("R7 id in bypass", 4);
    wr_cyc('h0, 'h00, 0); chk_mode("R7 exit", 0); chk("R7 bypass cleared", int'(bypass), 0);
    unlock(0); wr_cyc(U0, 'h20, 0); wr_cyc('h9, 'hF0, 0);
    chk("R4 f0 clears bypass", int'(bypass), 0);
    chk_array("R7");

    // R8 sector erase
    unlock(0); wr_cyc(U0, 'h80, 0); wr_cyc(U0, 'h11, 0); chk_mode("R8 bad second key", 0);
    unlock(0); wr_cyc(U0, 'h80, 0); unlock(0); wr_cyc('h10, 'h10, 0);
    chk_mode("R8 chip needs unlock addr", 0);
    unlock(0); wr_cyc(U0, 'h80, 0);
    wr_cyc(U0, 'hAA, 0); chk_mode("R8 erase key a", 6);
    wr_cyc(U1, 'h55, 0); chk_mode("R8 erase key b", 7);
    busy_cnt = 0;
    wr_cyc('h2F3, 'h30, 0);
    chk_mode("R8 erasing", 8); chk("R8 erase strobe", int'(erase), 1);
    chk("R8 sector base", int'(op_addr), 'h200);
    chk("R11 ro busy", int'(ro_busy), 1);
    wait_idle("R8");
    chk("R8 sector busy cycles", busy_cnt, 128);
    chk_mode("R8 sector done", 0);
    for (int a = 'h200; a < 'h400; a++) ref_mem[a] = 8'hFF;
    chk_array("R8 sector");

    // R9 writes during erase are ignored
    unlock(0); wr_cyc(U0, 'hA0, 0); wr_cyc('h10, 'h00, 0); model_prog('h10, 32'h0, 0);
    unlock(0); wr_cyc(U0, 'h80, 0); unlock(0);
    busy_cnt = 0;
    wr_cyc('h345, 'h30, 0);
    wr_cyc(U0, 'hAA, 0); chk_mode("R9 key ignored", 8);
    wr_cyc('h0, 'hF0, 0); chk_mode("R9 f0 ignored", 8);
    wr_cyc('h10, 'hA0, 0); chk_mode("R9 cmd ignored", 8);
    wait_idle("R9");
    chk("R9 busy cycles", busy_cnt, 128);
    chk_mode("R9 done", 0);
    chk_array("R9");

    // R8 chip erase under bypass
    unlock(0); wr_cyc(U0, 'h20, 0); wr_cyc('h77, 'h80, 0); chk_mode("R7 setup in bypass", 5);
    unlock(0);
    busy_cnt = 0;
    wr_cyc(U0, 'h10, 0);
    chk_mode("R8 chip erasing", 8); chk("R8 chip base", int'(op_addr), 0);
    wait_idle("R8 chip");
    chk("R8 chip busy cycles", busy_cnt, 256);
    chk_mode("R8 chip done bypass", 2); chk("R7 bypass after erase", int'(bypass), 1);
    for (int a = 0; a < DEPTH; a++) ref_mem[a] = 8'hFF;
    chk_array("R8 chip");
    wr_cyc('h0, 'h00, 0); chk_mode("R3 unknown in bypass", 0);
    chk("R3 bypass cleared", int'(bypass), 0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule